// File: doc/BRIEF.md
# Rename Source Override Network

This block sits right after the alias-table read in a three-wide rename stage. The table hands it one physical tag for each source of each micro-op in the group. The block corrects those tags for two kinds of change that the table has not yet seen.

The first correction handles retirement. A source tag that points into the reorder buffer may match an entry that is retiring in this same cycle. That entry's value is no longer in the reorder buffer, so the block turns the source into a pointer to the retirement register file, indexed by the source's logical name.

The second correction handles dependences inside the group. A younger micro-op may read a logical register that an older micro-op of the same group writes. That source takes the newly allocated tag of the nearest such older writer.

The logic is combinational. The corrected tags and the micro-op valid bits leave through a single register stage.

A tag is PW+1 bits wide. Bit PW is the file-select flag: 1 means the retirement register file and 0 means the reorder buffer. Bits PW-1:0 hold the index. A logical name is LW bits wide, and its top bit marks the floating-point class. Flattened vectors put micro-op i, source s at slot i*NSRC+s, least significant first.

Top module: `rename_ovr_top`

## Requirements
- R1: A source tag with flag 0 whose index equals the tag of a retiring slot that is valid this cycle is replaced by {1, logical source name zero-extended to PW bits}.
- R2: A source tag whose flag is already 1 is never altered by retirement, even when its index equals a valid retiring tag.
- R3: A retiring slot whose valid bit is 0 has no effect, even when its tag equals a source index.
- R4: The sources of micro-op 0 never take an allocator tag.
- R5: A source of micro-op 1 whose logical name equals micro-op 0's destination, with micro-op 0 valid and writing a destination, becomes {0, allocator tag of micro-op 0}.
- R6: For micro-op 2, a matching live micro-op 1 supplies the override ahead of micro-op 0. A matching live micro-op 0 supplies it only when micro-op 1 does not match.
- R7: When both overrides apply to one source, the intra-group allocator tag wins over the retirement pointer.
- R8: An older micro-op that is invalid, or that writes no destination, supplies no override.
- R9: Outputs change only at a clock edge, one cycle after their inputs. The valid outputs equal the previous cycle's micro-op valid bits. A synchronous active-low reset clears every output to zero.
- R10: Logical names that differ only in the class bit (integer versus floating point) never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uop_valid | input | NUOP | Micro-op valid bits |
| uop_has_dst | input | NUOP | Micro-op writes a destination |
| uop_lsrc | input | NUOP*NSRC*LW | Logical source names |
| uop_ldst | input | NUOP*LW | Logical destination names |
| arr_psrc | input | NUOP*NSRC*(PW+1) | Source tags read from the alias table |
| alloc_pdst | input | NUOP*PW | New destination tags from the allocator |
| ret_valid | input | NRET | Retiring slot valid bits |
| ret_tag | input | NRET*PW | Reorder-buffer tags retiring this cycle |
| out_valid | output | NUOP | Registered micro-op valid bits |
| out_psrc | output | NUOP*NSRC*(PW+1) | Registered final source tags |

## Verification
The bench sweeps every combination of source names, destination names and live bits for the two older micro-ops, and varies the retiring slots and their valid bits at the same time. This catches several distinct faults:
- A priority chain scanned in the wrong direction gives micro-op 2 the tag of micro-op 0 instead of micro-op 1.
- Reversed override order hands out an RRF pointer where a fresh allocator tag belongs.
- A comparator that skips the file-select flag rewrites tags that already point to the register file.
- A comparator that skips a slot's valid bit reacts to slots that are not retiring.

Directed cases cover the class bit, reset, and one-cycle latency. A design that cut the class bit would forward across the register classes. A design with an extra or missing register stage would show the new tag early or late.

// File: rtl/ren_ovr_pkg.sv
// Shared types for the rename source override network.
// Assumes: tags are {file-select flag, index}, where flag 1 selects the
// retirement register file.
package ren_ovr_pkg;

    // Which correction produced a final source tag
    typedef enum logic [1:0] {
        SEL_ARRAY  = 2'd0,
        SEL_RETIRE = 2'd1,
        SEL_GROUP  = 2'd2
    } ovr_sel_e;

endpackage

// File: rtl/ren_retire_ovr.sv
// Retirement override for one source.
// Does: compares the array tag index against every valid retiring tag.
//   On a hit, it returns a register-file pointer indexed by the logical
//   source name.
// Assumes: only reorder-buffer tags (flag 0) can retire, and LW <= PW.
module ren_retire_ovr #(
    parameter int PW   = 6,
    parameter int LW   = 5,
    parameter int NRET = 3
) (
    input  logic [PW:0]        arr_tag,
    input  logic [LW-1:0]      lsrc,
    input  logic [NRET-1:0]    ret_valid,
    input  logic [NRET*PW-1:0] ret_tag,
    output logic [PW:0]        tag_o,
    output logic               hit_o
);

    logic [NRET-1:0] slot_hit;

    // One comparator per retiring slot
    for (genvar k = 0; k < NRET; k++) begin : g_cmp
        assign slot_hit[k] = ret_valid[k] && !arr_tag[PW]
                             && (ret_tag[k*PW +: PW] == arr_tag[PW-1:0]);
    end

    // Select the register-file pointer or keep the array tag
    always_comb begin
        hit_o = |slot_hit;
        tag_o = hit_o ? {1'b1, PW'(lsrc)} : arr_tag;
    end

endmodule

// File: rtl/ren_group_bypass.sv
// Intra-group dependence override for one source.
// Does: searches the NOLD older micro-ops. The youngest live one whose
//   destination name equals the source name supplies its allocator tag.
// Assumes: older micro-ops are ordered oldest first (index 0), and
//   NOLD >= 1.
module ren_group_bypass #(
    parameter int PW   = 6,
    parameter int LW   = 5,
    parameter int NOLD = 1
) (
    input  logic [LW-1:0]      lsrc,
    input  logic [NOLD-1:0]    older_live,
    input  logic [NOLD*LW-1:0] older_ldst,
    input  logic [NOLD*PW-1:0] older_pdst,
    output logic               hit_o,
    output logic [PW-1:0]      pdst_o
);

    // Priority scan: a later (younger) match overwrites an earlier one
    always_comb begin
        hit_o  = 1'b0;
        pdst_o = '0;
        for (int j = 0; j < NOLD; j++) begin
            if (older_live[j] && (older_ldst[j*LW +: LW] == lsrc)) begin
                hit_o  = 1'b1;
                pdst_o = older_pdst[j*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/rename_ovr_top.sv
// Rename source override network (top).
// Does: applies retirement overrides to the array source tags, then lets
//   intra-group older-writer overrides take precedence, then registers the
//   result together with the micro-op valid bits.
// Assumes: the alias table is read in the same cycle; micro-op 0 is the
//   oldest in the group.
module rename_ovr_top
    import ren_ovr_pkg::*;
#(
    parameter int NUOP = 3,
    parameter int NSRC = 2,
    parameter int NRET = 3,
    parameter int PW   = 6,
    parameter int LW   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUOP-1:0]            uop_valid,
    input  logic [NUOP-1:0]            uop_has_dst,
    input  logic [NUOP*NSRC*LW-1:0]    uop_lsrc,
    input  logic [NUOP*LW-1:0]         uop_ldst,
    input  logic [NUOP*NSRC*(PW+1)-1:0] arr_psrc,
    input  logic [NUOP*PW-1:0]         alloc_pdst,
    input  logic [NRET-1:0]            ret_valid,
    input  logic [NRET*PW-1:0]         ret_tag,
    output logic [NUOP-1:0]            out_valid,
    output logic [NUOP*NSRC*(PW+1)-1:0] out_psrc
);

    localparam int TW    = PW + 1;
    localparam int NSLOT = NUOP * NSRC;

    logic [NUOP-1:0]     uop_live;
    logic [NSLOT*TW-1:0] final_tag;

    // A micro-op can supply an override only if it is valid and writes
    assign uop_live = uop_valid & uop_has_dst;

    for (genvar i = 0; i < NUOP; i++) begin : g_uop
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            localparam int SL = i * NSRC + s;
            logic [TW-1:0] ret_out;
            logic          ret_hit;
            logic          grp_hit;
            logic [PW-1:0] grp_pdst;
            ovr_sel_e      sel;

            ren_retire_ovr #(.PW(PW), .LW(LW), .NRET(NRET)) u_ret (
                .arr_tag   (arr_psrc[SL*TW +: TW]),
                .lsrc      (uop_lsrc[SL*LW +: LW]),
                .ret_valid (ret_valid),
                .ret_tag   (ret_tag),
                .tag_o     (ret_out),
                .hit_o     (ret_hit)
            );

            if (i > 0) begin : g_byp
                ren_group_bypass #(.PW(PW), .LW(LW), .NOLD(i)) u_byp (
                    .lsrc       (uop_lsrc[SL*LW +: LW]),
                    .older_live (uop_live[i-1:0]),
                    .older_ldst (uop_ldst[i*LW-1:0]),
                    .older_pdst (alloc_pdst[i*PW-1:0]),
                    .hit_o      (grp_hit),
                    .pdst_o     (grp_pdst)
                );
            end else begin : g_oldest
                assign grp_hit  = 1'b0;
                assign grp_pdst = '0;
            end

            // Group override wins over retirement, which wins over the array
            always_comb begin
                if (grp_hit)      sel = SEL_GROUP;
                else if (ret_hit) sel = SEL_RETIRE;
                else              sel = SEL_ARRAY;
                case (sel)
                    SEL_GROUP:  final_tag[SL*TW +: TW] = {1'b0, grp_pdst};
                    SEL_RETIRE: final_tag[SL*TW +: TW] = ret_out;
                    default:    final_tag[SL*TW +: TW] = arr_psrc[SL*TW +: TW];
                endcase
            end
        end
    end

    // Output stage: capture final tags and valid bits once per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_psrc  <= '0;
        end else begin
            out_valid <= uop_valid;
            out_psrc  <= final_tag;
        end
    end

endmodule

// File: rtl/rename_ovr_chk.sv
// Checker for rename_ovr_top, attached by bind.
// Does: keeps its own copy of the previous cycle's inputs and relates them
//   to the registered outputs.
// Assumes: NUOP >= 3 and synchronous active-low reset.
module rename_ovr_chk #(
    parameter int NUOP = 3,
    parameter int NSRC = 2,
    parameter int NRET = 3,
    parameter int PW   = 6,
    parameter int LW   = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUOP-1:0]             uop_valid,
    input logic [NUOP-1:0]             uop_has_dst,
    input logic [NUOP*NSRC*LW-1:0]     uop_lsrc,
    input logic [NUOP*LW-1:0]          uop_ldst,
    input logic [NUOP*NSRC*(PW+1)-1:0] arr_psrc,
    input logic [NUOP*PW-1:0]          alloc_pdst,
    input logic [NRET-1:0]             ret_valid,
    input logic [NRET*PW-1:0]          ret_tag,
    input logic [NUOP-1:0]             out_valid,
    input logic [NUOP*NSRC*(PW+1)-1:0] out_psrc
);

    localparam int TW = PW + 1;

    logic                        primed;
    logic [NUOP-1:0]             p_valid, p_live;
    logic [NUOP*NSRC*LW-1:0]     p_lsrc;
    logic [NUOP*LW-1:0]          p_ldst;
    logic [NUOP*NSRC*TW-1:0]     p_arr;
    logic [NUOP*PW-1:0]          p_alloc;
    logic [NRET-1:0]             p_rv;
    logic [NRET*PW-1:0]          p_rt;

    // Capture the inputs that produced the current outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed  <= 1'b0;
            p_valid <= '0;
            p_live  <= '0;
            p_lsrc  <= '0;
            p_ldst  <= '0;
            p_arr   <= '0;
            p_alloc <= '0;
            p_rv    <= '0;
            p_rt    <= '0;
        end else begin
            primed  <= 1'b1;
            p_valid <= uop_valid;
            p_live  <= uop_valid & uop_has_dst;
            p_lsrc  <= uop_lsrc;
            p_ldst  <= uop_ldst;
            p_arr   <= arr_psrc;
            p_alloc <= alloc_pdst;
            p_rv    <= ret_valid;
            p_rt    <= ret_tag;
        end
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> out_valid == p_valid); // R9

    for (genvar s = 0; s < NSRC; s++) begin : g_s
        logic [TW-1:0] o0, o1, o2;
        logic          stale0;
        assign o0 = out_psrc[(0*NSRC+s)*TW +: TW];
        assign o1 = out_psrc[(1*NSRC+s)*TW +: TW];
        assign o2 = out_psrc[(2*NSRC+s)*TW +: TW];

        // Oldest output still names a tag that was retiring
        always_comb begin
            stale0 = 1'b0;
            for (int k = 0; k < NRET; k++)
                if (p_rv[k] && p_rt[k*PW +: PW] == o0[PW-1:0]) stale0 = 1'b1;
        end

        AST_OLDEST_RRF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            primed && p_arr[(0*NSRC+s)*TW + PW]
            |-> o0 == p_arr[(0*NSRC+s)*TW +: TW]); // R2

        AST_OLDEST_NO_STALE: assert property (@(posedge clk) disable iff (!rst_n)
            primed && !o0[PW] |-> !stale0); // R1

        AST_U1_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
            primed && p_live[0] && p_ldst[0 +: LW] == p_lsrc[(1*NSRC+s)*LW +: LW]
            |-> o1 == {1'b0, p_alloc[0 +: PW]}); // R5

        AST_U2_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            primed && p_live[1] && p_ldst[LW +: LW] == p_lsrc[(2*NSRC+s)*LW +: LW]
            |-> o2 == {1'b0, p_alloc[PW +: PW]}); // R6
    end

endmodule

bind rename_ovr_top rename_ovr_chk #(
    .NUOP(NUOP), .NSRC(NSRC), .NRET(NRET), .PW(PW), .LW(LW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .uop_has_dst(uop_has_dst),
    .uop_lsrc(uop_lsrc), .uop_ldst(uop_ldst), .arr_psrc(arr_psrc),
    .alloc_pdst(alloc_pdst), .ret_valid(ret_valid), .ret_tag(ret_tag),
    .out_valid(out_valid), .out_psrc(out_psrc)
);

// File: tb/rename_ovr_top_tb_top.sv
module rename_ovr_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUOP = 3, NSRC = 2, NRET = 3, PW = 6, LW = 5;
    localparam int TW = PW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NUOP-1:0] u_valid, u_hasd;
    logic [LW-1:0]   lsrc_a [NUOP][NSRC];
    logic [LW-1:0]   ldst_a [NUOP];
    logic [TW-1:0]   arr_a  [NUOP][NSRC];
    logic [PW-1:0]   alloc_a[NUOP];
    logic [NRET-1:0] rv;
    logic [PW-1:0]   rt_a   [NRET];

    logic [NUOP*NSRC*LW-1:0] p_lsrc;
    logic [NUOP*LW-1:0]      p_ldst;
    logic [NUOP*NSRC*TW-1:0] p_arr;
    logic [NUOP*PW-1:0]      p_alloc;
    logic [NRET*PW-1:0]      p_rt;
    logic [NUOP-1:0]         out_valid;
    logic [NUOP*NSRC*TW-1:0] out_psrc;

    // Pack bench arrays into the flattened port vectors
    always_comb begin
        for (int i = 0; i < NUOP; i++) begin
            p_ldst[i*LW +: LW]  = ldst_a[i];
            p_alloc[i*PW +: PW] = alloc_a[i];
            for (int s = 0; s < NSRC; s++) begin
                p_lsrc[(i*NSRC+s)*LW +: LW] = lsrc_a[i][s];
                p_arr[(i*NSRC+s)*TW +: TW]  = arr_a[i][s];
            end
        end
        for (int k = 0; k < NRET; k++) p_rt[k*PW +: PW] = rt_a[k];
    end

    rename_ovr_top #(.NUOP(NUOP), .NSRC(NSRC), .NRET(NRET), .PW(PW), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .uop_valid(u_valid), .uop_has_dst(u_hasd),
        .uop_lsrc(p_lsrc), .uop_ldst(p_ldst), .arr_psrc(p_arr),
        .alloc_pdst(p_alloc), .ret_valid(rv), .ret_tag(p_rt),
        .out_valid(out_valid), .out_psrc(out_psrc)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    function automatic logic [TW-1:0] got(int i, int s);
        return out_psrc[(i*NSRC+s)*TW +: TW];
    endfunction

    // Reference model built from the requirements
    function automatic logic [TW-1:0] expect_tag(int i, int s, output string req);
        logic [TW-1:0] e;
        bit retired;
        e = arr_a[i][s];
        retired = 1'b0;
        req = (i == 0) ? "R4" : "R8";
        if (e[PW]) begin
            req = "R2";
        end else begin
            for (int k = 0; k < NRET; k++) begin
                if (rt_a[k] == e[PW-1:0]) begin
                    if (rv[k]) retired = 1'b1;
                    else if (!retired) req = "R3";
                end
            end
            if (retired) begin
                e = {1'b1, PW'(lsrc_a[i][s])};
                req = "R1";
            end
        end
        if (i > 0) begin
            for (int j = 0; j < i; j++) begin
                if (u_valid[j] && u_hasd[j] && ldst_a[j] == lsrc_a[i][s]) begin
                    e = {1'b0, alloc_a[j]};
                    req = retired ? "R7" : ((i == 1) ? "R5" : "R6");
                end
            end
        end
        return e;
    endfunction

    task automatic check(string req, logic [TW-1:0] act, logic [TW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Check every source and the valid bits against the held inputs
    task automatic check_all();
        string r;
        logic [TW-1:0] e;
        total++;
        if (out_valid !== u_valid) begin
            bad++;
            $display("FAIL R9: actual=%b expected=%b", out_valid, u_valid);
        end
        for (int i = 0; i < NUOP; i++)
            for (int s = 0; s < NSRC; s++) begin
                e = expect_tag(i, s, r);
                check(r, got(i, s), e);
            end
    endtask

    task automatic set_base();
        u_valid = 3'b111;
        u_hasd  = 3'b111;
        for (int i = 0; i < NUOP; i++) begin
            ldst_a[i]  = LW'(20 + i);
            alloc_a[i] = PW'(40 + i);
            for (int s = 0; s < NSRC; s++) begin
                lsrc_a[i][s] = LW'(4 + i*NSRC + s);
                arr_a[i][s]  = {1'b0, PW'(10 + i*NSRC + s)};
            end
        end
        arr_a[0][1] = {1'b1, PW'(11)};
        rv = '0;
        for (int k = 0; k < NRET; k++) rt_a[k] = PW'(60 + k);
    endtask

    initial begin
        logic [TW-1:0] hold;
        set_base();
        repeat (3) @(negedge clk);
        // R9: reset clears outputs
        check("R9", TW'(out_psrc[TW-1:0]), '0);
        total++;
        if (out_valid !== '0 || out_psrc !== '0) begin
            bad++;
            $display("FAIL R9: actual=%b/%h expected=0/0", out_valid, out_psrc);
        end
        rst_n = 1'b1;

        // R10: class bit separates names
        set_base();
        lsrc_a[1][0] = 5'h11;
        ldst_a[0]    = 5'h01;
        @(negedge clk);
        check("R10", got(1, 0), arr_a[1][0]);

        // R9: one-cycle latency, no change before the edge
        hold = got(1, 0);
        lsrc_a[1][0] = 5'h01;
        #1;
        check("R9", got(1, 0), hold);
        @(negedge clk);
        check("R9", got(1, 0), {1'b0, alloc_a[0]});

        // R3: slot not valid but tag matches
        set_base();
        rt_a[0] = PW'(12);
        rv = 3'b000;
        @(negedge clk);
        check("R3", got(1, 0), arr_a[1][0]);

        // Example chain: r1+r3->r3, r3+r2->r3, r3+r4->r5 (R5, R6)
        set_base();
        lsrc_a[0][0] = 1; lsrc_a[0][1] = 3; ldst_a[0] = 3;
        lsrc_a[1][0] = 3; lsrc_a[1][1] = 2; ldst_a[1] = 3;
        lsrc_a[2][0] = 3; lsrc_a[2][1] = 4; ldst_a[2] = 5;
        @(negedge clk);
        check("R5", got(1, 0), {1'b0, alloc_a[0]});
        check("R6", got(2, 0), {1'b0, alloc_a[1]});
        check("R4", got(0, 1), arr_a[0][1]);

        // Sweep: names, destinations, live bits and retirement pattern
        for (int it = 0; it < 2304; it++) begin
            int v;
            set_base();
            v = it;
            lsrc_a[1][0] = LW'(1 + v % 2); v /= 2;
            lsrc_a[1][1] = LW'(1 + v % 2); v /= 2;
            lsrc_a[2][0] = LW'(1 + v % 2); v /= 2;
            lsrc_a[2][1] = LW'(1 + v % 2); v /= 2;
            ldst_a[0]    = LW'(1 + v % 3); v /= 3;
            ldst_a[1]    = LW'(1 + v % 3); v /= 3;
            u_valid[0] = v[0]; u_hasd[0] = v[1];
            u_valid[1] = v[2]; u_hasd[1] = v[3];
            rv = NRET'(it % 8);
            if (it[3]) begin
                rt_a[0] = 14; rt_a[1] = 15; rt_a[2] = 13;
            end else begin
                rt_a[0] = 10; rt_a[1] = 11; rt_a[2] = 12;
            end
            @(negedge clk);
            check_all();
        end

        // R9: reset after traffic clears outputs again
        rst_n = 1'b0;
        @(negedge clk);
        total++;
        if (out_valid !== '0 || out_psrc !== '0) begin
            bad++;
            $display("FAIL R9: actual=%b/%h expected=0/0", out_valid, out_psrc);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule